// File: doc/BRIEF.md
# Coprocessor Instruction Handshake Sequencer

This block runs the core side of the exchange between a processor core and an attached coprocessor for three kinds of coprocessor instruction: register moves in either direction, internal data operations and memory load/store. A start strobe with an operation code launches the exchange. The block presents an opening request to the coprocessor and keeps polling for as long as the coprocessor replies that it is busy. During that wait a pending, unmasked exception ends the instruction. A refusal by the coprocessor ends it with an undefined-instruction trap.

For loads and stores the block screens the base address before any coprocessor contact. It then produces a post-indexed burst of word addresses that advances for as long as the coprocessor asks for another word. Three saturating counters keep a tally of internal, coprocessor and non-sequential memory cycles.

Top module: `cop_hs_seq`

## Requirements
- R1: After reset, `cp_req_o` is 0 (none), `mem_req_o` and `done_o` are 0, `status_o` is 0 (ok) and all three cycle counters are 0.
- R2: A start accepted while idle is followed in the next cycle by request code 1 (first). Every response code 1 (busy) given to request 1 or 2 is followed by request code 2 (busy) and adds one to the internal-cycle counter. Response codes are 0 done, 1 busy, 2 cannot, 3 increment.
- R3: When a busy response arrives while an exception is pending, the block issues request code 3 (interrupt) for exactly one cycle and then completes. Reset request wins and gives status 2. Otherwise an unmasked fast interrupt gives status 3. Otherwise an unmasked normal interrupt gives status 4. A masked line is ignored.
- R4: A cannot response to request 1 or 2 completes with status 1 (undefined). For operation 1 (read from coprocessor) the result becomes the flag-preserving constant `CANT_VALUE`.
- R5: Operation codes are 0 write to coprocessor, 1 read from coprocessor, 2 data operation, 3 load, 4 store. Acceptance of 0 or 1 (response 0 or 3) adds one coprocessor cycle. Acceptance of 1 also adds one internal cycle and captures `cp_rdata_i` as the result.
- R6: For operations 3 and 4, a base address with any bit at or above `LEGAL_BITS` set completes with status 5 (abort) and no request to the coprocessor. So does a store whose base is below `VEC_TOP`. A load below `VEC_TOP` proceeds.
- R7: An accepted load or store issues request code 4 (data) with `mem_req_o` high. The first word is at the base and each increment response advances the address by 4 for one more word. A done response ends the burst with status 0. `mem_we_o` is high only for stores.
- R8: `mem_abort_i` during a transfer cycle ends the burst with status 5, with no further words.
- R9: Each cycle counter stops at its all-ones value.
- R10: `done_o` is a one-cycle pulse. `status_o` and `rd_result_o` hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe, accepted only when idle |
| op_i | input | 3 | Operation code |
| addr_i | input | AW | Base address for load/store |
| cp_resp_i | input | 2 | Coprocessor response code |
| cp_rdata_i | input | DW | Value offered by the coprocessor on a read |
| rst_req_i | input | 1 | Pending reset exception |
| fiq_i | input | 1 | Fast interrupt request |
| irq_i | input | 1 | Normal interrupt request |
| fiq_mask_i | input | 1 | Masks the fast interrupt |
| irq_mask_i | input | 1 | Masks the normal interrupt |
| mem_abort_i | input | 1 | Memory abort for the current transfer word |
| cp_req_o | output | 3 | Request code to the coprocessor |
| mem_req_o | output | 1 | Memory transfer this cycle |
| mem_we_o | output | 1 | Transfer is a store |
| mem_addr_o | output | AW | Word address of the transfer |
| done_o | output | 1 | Completion pulse |
| status_o | output | 3 | Completion status |
| rd_result_o | output | DW | Result of a read from the coprocessor |
| icyc_o | output | CNT_W | Internal-cycle counter |
| ccyc_o | output | CNT_W | Coprocessor-cycle counter |
| ncyc_o | output | CNT_W | Non-sequential memory-cycle counter |

## Verification
The hardest situations to reach are the ones where two decisions compete in one cycle. One is an exception line that is active while the coprocessor is still answering busy. The other is a memory abort that lands in the middle of an increment burst. The bench plays the coprocessor on the falling edge from a per-run script that gives a busy count, a final answer, an increment count and an abort word index. Exception lines are held throughout the run, so each priority and mask combination meets the first busy response. A deliberately long busy script pushes the internal counter to its ceiling.

// File: rtl/cphs_pkg.sv
package cphs_pkg;
   typedef enum logic [2:0] {
      OP_TO_CP   = 3'd0,
      OP_FROM_CP = 3'd1,
      OP_CPDATA  = 3'd2,
      OP_LOAD    = 3'd3,
      OP_STORE   = 3'd4
   } cp_op_e;

   typedef enum logic [1:0] {
      RSP_DONE = 2'd0,
      RSP_BUSY = 2'd1,
      RSP_CANT = 2'd2,
      RSP_INC  = 2'd3
   } cp_rsp_e;

   typedef enum logic [2:0] {
      REQ_NONE  = 3'd0,
      REQ_FIRST = 3'd1,
      REQ_BUSY  = 3'd2,
      REQ_INTR  = 3'd3,
      REQ_DATA  = 3'd4
   } cp_req_e;

   typedef enum logic [2:0] {
      FIN_OK    = 3'd0,
      FIN_UNDEF = 3'd1,
      FIN_RESET = 3'd2,
      FIN_FIQ   = 3'd3,
      FIN_IRQ   = 3'd4,
      FIN_ABORT = 3'd5
   } fin_e;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_FIRST  = 3'd1,
      S_WAIT   = 3'd2,
      S_NOTIFY = 3'd3,
      S_XFER   = 3'd4,
      S_FIN    = 3'd5
   } seq_st_e;
endpackage

// File: rtl/cphs_addr_chk.sv
module cphs_addr_chk #(
   parameter int          AW         = 32,
   parameter int          LEGAL_BITS = 26,
   parameter logic [31:0] VEC_TOP    = 32'h20
) (
   input  logic [AW-1:0] addr_i,
   input  logic          is_store_i,
   output logic          fault_o
);
   logic range_bad;
   logic vec_bad;

   generate
      if (LEGAL_BITS >= AW) begin : g_no_range
         assign range_bad = 1'b0;
      end else begin : g_range
         assign range_bad = |addr_i[AW-1:LEGAL_BITS];
      end

      if (VEC_TOP == 32'h0) begin : g_no_vec
         assign vec_bad = 1'b0;
      end else begin : g_vec
         localparam logic [AW-1:0] VLIM = AW'(VEC_TOP);
         assign vec_bad = is_store_i && (addr_i < VLIM);
      end
   endgenerate

   assign fault_o = range_bad | vec_bad;
endmodule

// File: rtl/cphs_addr_gen.sv
module cphs_addr_gen #(
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] base_i,
   input  logic          step_i,
   output logic [AW-1:0] addr_o
);
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       addr_q <= '0;
      else if (load_i)  addr_q <= base_i;
      else if (step_i)  addr_q <= addr_q + STEP;
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/cphs_sat_cnt.sv
module cphs_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == TOP) |=> (cnt_q == TOP)); // R9
endmodule

// File: rtl/cop_hs_seq.sv
module cop_hs_seq
   import cphs_pkg::*;
#(
   parameter int          AW         = 32,
   parameter int          DW         = 32,
   parameter int          CNT_W      = 16,
   parameter int          LEGAL_BITS = 26,
   parameter logic [31:0] VEC_TOP    = 32'h20,
   parameter logic [31:0] CANT_VALUE = 32'hF000_0000,
   parameter int          WORD_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [2:0]       op_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [1:0]       cp_resp_i,
   input  logic [DW-1:0]    cp_rdata_i,
   input  logic             rst_req_i,
   input  logic             fiq_i,
   input  logic             irq_i,
   input  logic             fiq_mask_i,
   input  logic             irq_mask_i,
   input  logic             mem_abort_i,
   output logic [2:0]       cp_req_o,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [AW-1:0]    mem_addr_o,
   output logic             done_o,
   output logic [2:0]       status_o,
   output logic [DW-1:0]    rd_result_o,
   output logic [CNT_W-1:0] icyc_o,
   output logic [CNT_W-1:0] ccyc_o,
   output logic [CNT_W-1:0] ncyc_o
);
   localparam int             NCNT    = 3;
   localparam logic [AW-1:0]  STEP    = AW'(WORD_BYTES);
   localparam logic [DW-1:0]  KEEPVAL = DW'(CANT_VALUE);

   generate
      if (AW < 8)                  begin : g_bad_aw  $error("AW too small");        end
      if (DW < 1)                  begin : g_bad_dw  $error("DW must be positive");  end
      if (CNT_W < 2)               begin : g_bad_cnt $error("CNT_W too small");     end
      if (LEGAL_BITS < 2)          begin : g_bad_lb  $error("LEGAL_BITS too small"); end
      if (WORD_BYTES < 1)          begin : g_bad_wb  $error("WORD_BYTES invalid");   end
   endgenerate

   seq_st_e         state_q;
   cp_op_e          op_q;
   fin_e            status_q;
   logic [DW-1:0]   rd_q;

   cp_op_e          op_in;
   cp_rsp_e         rsp;
   logic            in_ldst, in_store, addr_fault;
   logic            wait_st, accept, is_ldst_q, is_move_q;
   logic            exc_hit;
   fin_e            exc_code;
   logic            addr_load, addr_step;
   logic [NCNT-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_val [NCNT];

   assign op_in     = cp_op_e'(op_i);
   assign rsp       = cp_rsp_e'(cp_resp_i);
   assign in_store  = (op_in == OP_STORE);
   assign in_ldst   = (op_in == OP_LOAD) || in_store;
   assign wait_st   = (state_q == S_FIRST) || (state_q == S_WAIT);
   assign accept    = (rsp == RSP_DONE) || (rsp == RSP_INC);
   assign is_ldst_q = (op_q == OP_LOAD) || (op_q == OP_STORE);
   assign is_move_q = (op_q == OP_TO_CP) || (op_q == OP_FROM_CP);

   cphs_addr_chk #(.AW(AW), .LEGAL_BITS(LEGAL_BITS), .VEC_TOP(VEC_TOP)) u_chk (
      .addr_i     (addr_i),
      .is_store_i (in_store),
      .fault_o    (addr_fault)
   );

   // exception priority: reset, then fast, then normal interrupt
   always_comb begin
      exc_hit  = 1'b1;
      exc_code = FIN_OK;
      if (rst_req_i)                   exc_code = FIN_RESET;
      else if (fiq_i && !fiq_mask_i)   exc_code = FIN_FIQ;
      else if (irq_i && !irq_mask_i)   exc_code = FIN_IRQ;
      else                             exc_hit  = 1'b0;
   end

   assign addr_load = (state_q == S_IDLE) && start_i;
   assign addr_step = (state_q == S_XFER) && !mem_abort_i && (rsp == RSP_INC);

   cphs_addr_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_agen (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (addr_load),
      .base_i (addr_i),
      .step_i (addr_step),
      .addr_o (mem_addr_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         op_q     <= OP_TO_CP;
         status_q <= FIN_OK;
         rd_q     <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (start_i) begin
               op_q <= op_in;
               if (in_ldst && addr_fault) begin
                  status_q <= FIN_ABORT;
                  state_q  <= S_FIN;
               end else begin
                  state_q  <= S_FIRST;
               end
            end
            S_FIRST, S_WAIT: begin
               if (rsp == RSP_BUSY) begin
                  if (exc_hit) begin
                     status_q <= exc_code;
                     state_q  <= S_NOTIFY;
                  end else begin
                     state_q  <= S_WAIT;
                  end
               end else if (rsp == RSP_CANT) begin
                  status_q <= FIN_UNDEF;
                  if (op_q == OP_FROM_CP) rd_q <= KEEPVAL;
                  state_q  <= S_FIN;
               end else begin
                  if (op_q == OP_FROM_CP) rd_q <= cp_rdata_i;
                  if (is_ldst_q) begin
                     state_q  <= S_XFER;
                  end else begin
                     status_q <= FIN_OK;
                     state_q  <= S_FIN;
                  end
               end
            end
            S_NOTIFY: state_q <= S_FIN;
            S_XFER: begin
               if (mem_abort_i) begin
                  status_q <= FIN_ABORT;
                  state_q  <= S_FIN;
               end else if (rsp != RSP_INC) begin
                  status_q <= FIN_OK;
                  state_q  <= S_FIN;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      case (state_q)
         S_FIRST:  cp_req_o = REQ_FIRST;
         S_WAIT:   cp_req_o = REQ_BUSY;
         S_NOTIFY: cp_req_o = REQ_INTR;
         S_XFER:   cp_req_o = REQ_DATA;
         default:  cp_req_o = REQ_NONE;
      endcase
   end

   assign mem_req_o   = (state_q == S_XFER);
   assign mem_we_o    = (state_q == S_XFER) && (op_q == OP_STORE);
   assign done_o      = (state_q == S_FIN);
   assign status_o    = status_q;
   assign rd_result_o = rd_q;

   // counter 0 internal, 1 coprocessor, 2 non-sequential memory
   assign cnt_inc[0] = wait_st && ((rsp == RSP_BUSY) || (accept && op_q == OP_FROM_CP));
   assign cnt_inc[1] = wait_st && accept && is_move_q;
   assign cnt_inc[2] = (state_q == S_XFER);

   generate
      for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
         cphs_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (cnt_inc[gi]),
            .cnt_o (cnt_val[gi])
         );
      end
   endgenerate

   assign icyc_o = cnt_val[0];
   assign ccyc_o = cnt_val[1];
   assign ncyc_o = cnt_val[2];

   AST_FIRST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && start_i && !(in_ldst && addr_fault)) |=> (cp_req_o == REQ_FIRST)); // R2
   AST_INTR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req_o == REQ_INTR) |=> done_o); // R3
   AST_CANT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_st && rsp == RSP_CANT) |=> (done_o && status_o == FIN_UNDEF)); // R4
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && rsp == RSP_INC && !mem_abort_i) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + STEP)); // R7
   AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_abort_i) |=> (!mem_req_o && status_o == FIN_ABORT)); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10
endmodule

// File: tb/sim_cop_hs_seq.sv
module sim_cop_hs_seq;
   localparam int          AW    = 32;
   localparam int          DW    = 32;
   localparam int          CW    = 8;
   localparam logic [31:0] KEEP  = 32'hF000_0000;
   localparam logic [31:0] RDATA = 32'h1234_5678;

   typedef struct packed {
      logic [2:0] op;
      logic [7:0] busy;
      logic [1:0] fin;
      logic [3:0] inc;
      logic       rq, fq, iq, fm, im;
      logic [2:0] st;
      logic [4:0] xf;
      logic [7:0] di;
      logic [1:0] dc;
   } row_t;

   // op busy fin inc rst fiq irq fmask imask status xfers dI dC
   localparam int NROW = 14;
   localparam row_t TBL [NROW] = '{
      '{3'd0, 8'd0, 2'd0, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 5'd0, 8'd0, 2'd1},
      '{3'd0, 8'd3, 2'd0, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 5'd0, 8'd3, 2'd1},
      '{3'd1, 8'd2, 2'd0, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 5'd0, 8'd3, 2'd1},
      '{3'd2, 8'd1, 2'd2, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1, 5'd0, 8'd1, 2'd0},
      '{3'd1, 8'd0, 2'd2, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1, 5'd0, 8'd0, 2'd0},
      '{3'd2, 8'd2, 2'd0, 4'd0, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd4, 5'd0, 8'd1, 2'd0},
      '{3'd2, 8'd2, 2'd0, 4'd0, 1'b0,1'b0,1'b1,1'b0,1'b1, 3'd0, 5'd0, 8'd2, 2'd0},
      '{3'd2, 8'd2, 2'd0, 4'd0, 1'b0,1'b1,1'b1,1'b0,1'b0, 3'd3, 5'd0, 8'd1, 2'd0},
      '{3'd2, 8'd2, 2'd0, 4'd0, 1'b1,1'b1,1'b0,1'b0,1'b0, 3'd2, 5'd0, 8'd1, 2'd0},
      '{3'd2, 8'd2, 2'd0, 4'd0, 1'b0,1'b1,1'b1,1'b1,1'b0, 3'd4, 5'd0, 8'd1, 2'd0},
      '{3'd3, 8'd1, 2'd3, 4'd3, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 5'd4, 8'd1, 2'd0},
      '{3'd4, 8'd0, 2'd0, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 5'd1, 8'd0, 2'd0},
      '{3'd2, 8'd0, 2'd0, 4'd0, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0, 5'd0, 8'd0, 2'd0},
      '{3'd1, 8'd1, 2'd3, 4'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0, 5'd0, 8'd2, 2'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    op_i = '0;
   logic [AW-1:0] addr_i = '0;
   logic [1:0]    cp_resp_i = '0;
   logic [DW-1:0] cp_rdata_i = RDATA;
   logic          rst_req_i = 1'b0, fiq_i = 1'b0, irq_i = 1'b0;
   logic          fiq_mask_i = 1'b0, irq_mask_i = 1'b0, mem_abort_i = 1'b0;
   logic [2:0]    cp_req_o;
   logic          mem_req_o, mem_we_o, done_o;
   logic [AW-1:0] mem_addr_o;
   logic [2:0]    status_o;
   logic [DW-1:0] rd_result_o;
   logic [CW-1:0] icyc_o, ccyc_o, ncyc_o;

   int checks = 0;
   int errors = 0;

   // coprocessor script and observations
   int busy_left, inc_left, abort_at;
   logic [1:0] fin_rsp;
   int n_first, n_busy, n_intr, n_xfer;
   logic [AW-1:0] last_addr;
   bit addr_err, we_seen;

   always #5 clk = ~clk;

   cop_hs_seq #(.AW(AW), .DW(DW), .CNT_W(CW), .CANT_VALUE(KEEP)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
      .cp_resp_i(cp_resp_i), .cp_rdata_i(cp_rdata_i), .rst_req_i(rst_req_i),
      .fiq_i(fiq_i), .irq_i(irq_i), .fiq_mask_i(fiq_mask_i), .irq_mask_i(irq_mask_i),
      .mem_abort_i(mem_abort_i), .cp_req_o(cp_req_o), .mem_req_o(mem_req_o),
      .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .done_o(done_o),
      .status_o(status_o), .rd_result_o(rd_result_o), .icyc_o(icyc_o),
      .ccyc_o(ccyc_o), .ncyc_o(ncyc_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // coprocessor model: answers on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cp_resp_i   = 2'd0;
         mem_abort_i = 1'b0;
         case (cp_req_o)
            3'd1, 3'd2: begin
               if (cp_req_o == 3'd1) n_first++; else n_busy++;
               if (busy_left > 0) begin cp_resp_i = 2'd1; busy_left--; end
               else cp_resp_i = fin_rsp;
            end
            3'd3: n_intr++;
            3'd4: begin
               if (n_xfer > 0 && mem_addr_o != last_addr + 4) addr_err = 1'b1;
               last_addr = mem_addr_o;
               if (mem_we_o) we_seen = 1'b1;
               if (n_xfer == abort_at) mem_abort_i = 1'b1;
               if (inc_left > 0) begin cp_resp_i = 2'd3; inc_left--; end
               n_xfer++;
            end
            default: ;
         endcase
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic run(input logic [2:0] op, input logic [AW-1:0] base, input int busy,
                      input logic [1:0] fin, input int inc, input int abt);
      @(negedge clk);
      busy_left = busy; inc_left = inc; fin_rsp = fin; abort_at = abt;
      n_first = 0; n_busy = 0; n_intr = 0; n_xfer = 0;
      addr_err = 1'b0; we_seen = 1'b0; last_addr = '0;
      op_i = op; addr_i = base; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o) @(negedge clk);
   endtask

   logic [CW-1:0] pi, pc, pn;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cp_req_o == 3'd0 && !mem_req_o && !done_o, "R1 idle outputs", {cp_req_o, mem_req_o, done_o}, 0);
      chk(status_o == 3'd0, "R1 status", status_o, 0);
      chk(icyc_o == 0 && ccyc_o == 0 && ncyc_o == 0, "R1 counters", {icyc_o, ccyc_o, ncyc_o}, 0);

      for (int r = 0; r < NROW; r++) begin
         row_t v = TBL[r];
         bit exc = (v.st == 3'd2 || v.st == 3'd3 || v.st == 3'd4);
         rst_req_i = v.rq; fiq_i = v.fq; irq_i = v.iq; fiq_mask_i = v.fm; irq_mask_i = v.im;
         pi = icyc_o; pc = ccyc_o; pn = ncyc_o;
         run(v.op, 32'h100, int'(v.busy), v.fin, int'(v.inc), -1);
         chk(status_o == v.st, $sformatf("R3/R4 row %0d status", r), status_o, v.st);
         chk(n_first == 1, $sformatf("R2 row %0d first", r), n_first, 1);
         chk(n_busy == (exc ? 0 : int'(v.busy)), $sformatf("R2 row %0d busy reqs", r), n_busy, exc ? 0 : v.busy);
         chk(n_intr == (exc ? 1 : 0), $sformatf("R3 row %0d notice", r), n_intr, exc);
         chk(icyc_o - pi == v.di, $sformatf("R2/R5 row %0d icyc", r), icyc_o - pi, v.di);
         chk(ccyc_o - pc == CW'(v.dc), $sformatf("R5 row %0d ccyc", r), ccyc_o - pc, v.dc);
         chk(n_xfer == int'(v.xf) && ncyc_o - pn == CW'(v.xf), $sformatf("R7 row %0d words", r), n_xfer, v.xf);
         if (v.xf != 0) begin
            chk(!addr_err && last_addr == 32'h100 + 4 * (v.xf - 1), $sformatf("R7 row %0d addr", r), last_addr, 32'h100 + 4 * (v.xf - 1));
            chk(we_seen == (v.op == 3'd4), $sformatf("R7 row %0d write enable", r), we_seen, v.op == 3'd4);
         end
         if (v.op == 3'd1)
            chk(rd_result_o == (v.st == 3'd1 ? KEEP : RDATA), $sformatf("R4/R5 row %0d result", r), rd_result_o, v.st == 3'd1 ? KEEP : RDATA);
         @(negedge clk);
         chk(!done_o && status_o == v.st, $sformatf("R10 row %0d pulse/hold", r), {done_o, status_o}, v.st);
      end
      rst_req_i = 0; fiq_i = 0; irq_i = 0; fiq_mask_i = 0; irq_mask_i = 0;

      // R6 address beyond legal range
      run(3'd3, 32'h0400_0000, 0, 2'd0, 0, -1);
      chk(status_o == 3'd5 && n_first == 0, "R6 range fault", {status_o, 8'(n_first)}, 16'h500);
      // R6 store into vector area
      run(3'd4, 32'h10, 0, 2'd0, 0, -1);
      chk(status_o == 3'd5 && n_first == 0 && n_xfer == 0, "R6 vector store", {status_o, 8'(n_first)}, 16'h500);
      // R6 load from vector area allowed
      run(3'd3, 32'h10, 0, 2'd0, 0, -1);
      chk(status_o == 3'd0 && n_xfer == 1 && last_addr == 32'h10, "R6 vector load", last_addr, 32'h10);
      // R8 abort on word index 2 of a six-word burst
      pn = ncyc_o;
      run(3'd3, 32'h200, 1, 2'd3, 5, 2);
      chk(status_o == 3'd5, "R8 abort status", status_o, 5);
      chk(n_xfer == 3 && last_addr == 32'h208, "R8 words before stop", n_xfer, 3);
      chk(ncyc_o - pn == 3, "R8 memory cycles", ncyc_o - pn, 3);
      // R9 saturation of the internal counter
      run(3'd2, 32'h0, 300, 2'd0, 0, -1);
      chk(icyc_o == 8'hFF && n_busy == 300, "R9 saturate", icyc_o, 8'hFF);
      run(3'd2, 32'h0, 4, 2'd0, 0, -1);
      chk(icyc_o == 8'hFF, "R9 hold at top", icyc_o, 8'hFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule